// File: doc/BRIEF.md
# Initialization Word Loader

This block runs once after reset and produces a 16-bit configuration word for a PHY's management registers. The word can come from one of three sources, and a two-bit mode input picks the source. In microcontroller mode an external agent supplies a slow clock and shifts the bits in, least significant first. In serial-memory mode the block is the master of a 3-wire serial EEPROM: it generates the clock, chip select and read command, then collects the 16 data bits. In strap mode the block builds the word directly from three capability pins.

After the word is complete it is frozen until the next reset, and a done flag is raised. The block also presents the PHY address it answers to. That address comes from the top five bits of a loaded word. In strap mode it is fixed at zero. The EEPROM sends its most significant bit first, but the word is filled from bit 0 upward. The stored word is therefore the bit-reverse of the memory contents, so the memory image must be reversed before it is programmed.

Top module: `init_word_loader`

## Requirements
- R1: The mode input is sampled once, in the first clock cycle after reset is released. 2'b01 selects microcontroller mode, 2'b10 selects serial-memory mode, and 2'b00 or 2'b11 select strap mode. Later changes to the mode input have no effect until the next reset.
- R2: During reset and after it is released, cfgDone, cfgWord, phyAddr, eeCs, eeClk and eeDi are all 0 until a source delivers data.
- R3: In microcontroller mode, serData is captured on each of the first 16 rising edges of mcuClk, seen after SYNC_STAGES synchronizer flops. The first captured bit lands in cfgWord bit 0 and the sixteenth in bit 15. Any later mcuClk edges are ignored.
- R4: In serial-memory mode, eeCs is high for the whole transfer and eeClk pulses only while eeCs is high. The transfer is exactly 25 eeClk periods. At the first 9 rising edges eeDi carries 1,1,0 followed by six address zeros. At every later rising edge eeDi is 0.
- R5: In serial-memory mode, the bit driven after the 9th rising edge is a dummy and is discarded. The bits driven after rising edges 10 to 25 are memory bits 15 down to 0. The first of these is stored in cfgWord bit 0, so cfgWord is the bit-reverse of the memory word.
- R6: Each high phase and each low phase of eeClk lasts HALF_CYCLES system clocks. Read data is sampled in the last system cycle of the high phase, so data may settle late in that phase.
- R7: In strap mode, cfgWord is strap10Hd in bit 0, strap10Fd in bit 1 and strapT4 in bit 2, with all other bits 0. cfgDone rises on the first clock edge after reset release, and phyAddr is 0.
- R8: In microcontroller and serial-memory modes, once cfgDone is high, phyAddr equals cfgWord[15:11].
- R9: Once cfgDone is high it stays high. cfgWord and phyAddr then no longer change, whatever happens on the strap pins, serData or mcuClk. After a serial-memory transfer, eeCs and eeClk stay low.
- R10: cfgWord and phyAddr read 0 while fewer than 16 bits have been collected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Load source select (01 microcontroller, 10 serial memory, 00/11 strap) |
| mcuClk | input | 1 | Shift clock from an external microcontroller |
| serData | input | 1 | Serial data from microcontroller or EEPROM |
| strap10Hd | input | 1 | Strap: 10 Mb/s half duplex capability |
| strap10Fd | input | 1 | Strap: 10 Mb/s full duplex capability |
| strapT4 | input | 1 | Strap: 100 Mb/s four-pair capability |
| eeClk | output | 1 | Generated EEPROM clock |
| eeCs | output | 1 | EEPROM chip select |
| eeDi | output | 1 | Command and address bits to the EEPROM |
| cfgWord | output | WORD_BITS (16) | Frozen configuration word |
| cfgDone | output | 1 | Word complete and locked |
| phyAddr | output | PHY_ADDR_BITS (5) | Address the PHY responds to |

## Verification
The bench builds the loader with HALF_CYCLES set to 4. A full 25-period EEPROM transfer then takes 200 system clocks, short enough to repeat with several memory images. Its phase lengths can still be counted exactly, and the late-settling read data, which changes 50 ns after each rising edge, falls inside the high phase before the sampling cycle. WORD_BITS and SYNC_STAGES keep their defaults of 16 and 2. The 16-edge limit, the bit reversal and the five-bit address field are therefore checked at their real sizes. The microcontroller clock is driven with four-cycle phases, which clears the synchronizer.

// File: rtl/iwl_pkg.sv
package iwl_pkg;

  typedef enum logic [1:0] {
    SRC_STRAP     = 2'b00,
    SRC_MCU       = 2'b01,
    SRC_EEPROM    = 2'b10,
    SRC_ALT_STRAP = 2'b11
  } srcSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadStrap;
  } dpCmd_t;

endpackage

// File: rtl/iwl_ctrl.sv
module iwl_ctrl
  import iwl_pkg::*;
#(
  parameter int HALF_CYCLES  = 50,
  parameter int WORD_BITS    = 16,
  parameter int EE_ADDR_BITS = 6,
  parameter int EE_ADDR      = 0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic [1:0] modeSel,
  input  logic   mcuClk,
  input  logic   serData,
  input  logic   wordDone,
  output dpCmd_t cmd,
  output logic   eeClk,
  output logic   eeCs,
  output logic   eeDi
);
  localparam int CMD_BITS  = 3 + EE_ADDR_BITS;
  localparam int TOTAL_CYC = CMD_BITS + WORD_BITS;
  localparam int DIV_W     = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int CYC_W     = $clog2(TOTAL_CYC + 1);
  localparam logic [CMD_BITS-1:0] READ_CMD = {3'b110, EE_ADDR_BITS'(EE_ADDR)};

  typedef enum logic [1:0] {ST_PICK, ST_MCU, ST_EE, ST_HOLD} ctlState_t;

  ctlState_t state;
  logic [DIV_W-1:0]       divCnt;
  logic                   phase;
  logic [CYC_W-1:0]       cycIdx;
  logic [CMD_BITS-1:0]    cmdShift;
  logic [SYNC_STAGES-1:0] clkSync, dataSync;
  logic                   clkPrev;
  logic                   phaseEnd, mcuRise;

  assign phaseEnd = (divCnt == DIV_W'(HALF_CYCLES - 1));
  assign mcuRise  = clkSync[SYNC_STAGES-1] & ~clkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_PICK;
      divCnt   <= '0;
      phase    <= 1'b0;
      cycIdx   <= '0;
      cmdShift <= '0;
      clkSync  <= '0;
      dataSync <= '0;
      clkPrev  <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], mcuClk};
      dataSync <= {dataSync[SYNC_STAGES-2:0], serData};
      clkPrev  <= clkSync[SYNC_STAGES-1];
      case (state)
        ST_PICK: begin
          cmdShift <= READ_CMD;
          case (srcSel_t'(modeSel))
            SRC_MCU:    state <= ST_MCU;
            SRC_EEPROM: state <= ST_EE;
            default:    state <= ST_HOLD;
          endcase
        end
        ST_MCU: if (wordDone) state <= ST_HOLD;
        ST_EE: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (phase) begin
              phase    <= 1'b0;
              cmdShift <= {cmdShift[CMD_BITS-2:0], 1'b0};
              if (cycIdx == CYC_W'(TOTAL_CYC - 1)) state <= ST_HOLD;
              else cycIdx <= cycIdx + 1'b1;
            end else begin
              phase <= 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd = '0;
    case (state)
      ST_PICK: cmd.loadStrap = (srcSel_t'(modeSel) != SRC_MCU) &&
                               (srcSel_t'(modeSel) != SRC_EEPROM);
      ST_MCU: begin
        cmd.shiftEn  = mcuRise;
        cmd.shiftBit = dataSync[SYNC_STAGES-1];
      end
      ST_EE: begin
        cmd.shiftEn  = phase && phaseEnd && (cycIdx >= CYC_W'(CMD_BITS));
        cmd.shiftBit = serData;
      end
      default: ;
    endcase
  end

  assign eeCs  = (state == ST_EE);
  assign eeClk = phase;
  assign eeDi  = eeCs & cmdShift[CMD_BITS-1];

  // R4: the memory clock never runs without chip select
  a_r4_clock_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    eeClk |-> eeCs);
  // R1: once a source is chosen the selection step never recurs
  a_r1_mode_sampled_once: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_PICK) |=> (state != ST_PICK));
  // R9: no shifting once the sequence is parked
  a_r9_hold_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (!eeCs && !eeClk));

endmodule

// File: rtl/iwl_datapath.sv
module iwl_datapath
  import iwl_pkg::*;
#(
  parameter int WORD_BITS     = 16,
  parameter int PHY_ADDR_BITS = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  input  logic   strap10Hd,
  input  logic   strap10Fd,
  input  logic   strapT4,
  output logic   wordDone,
  output logic [WORD_BITS-1:0]     cfgWord,
  output logic [PHY_ADDR_BITS-1:0] phyAddr
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic [WORD_BITS-1:0] wordReg;
  logic [CNT_W-1:0]     bitCnt;
  logic                 doneR;
  logic                 isStrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
      bitCnt  <= '0;
      doneR   <= 1'b0;
      isStrap <= 1'b0;
    end else if (!doneR) begin
      if (cmd.loadStrap) begin
        wordReg <= {{(WORD_BITS-3){1'b0}}, strapT4, strap10Fd, strap10Hd};
        doneR   <= 1'b1;
        isStrap <= 1'b1;
      end else if (cmd.shiftEn) begin
        wordReg <= {cmd.shiftBit, wordReg[WORD_BITS-1:1]};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(WORD_BITS - 1)) doneR <= 1'b1;
      end
    end
  end

  assign wordDone = doneR;
  assign cfgWord  = doneR ? wordReg : '0;
  assign phyAddr  = (doneR && !isStrap) ? wordReg[WORD_BITS-1 -: PHY_ADDR_BITS] : '0;

  // R9: completion is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> doneR);
  // R9: the word is locked after completion
  a_r9_word_frozen: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> $stable(wordReg));
  // R3: never more than one word of shifts
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_BITS));
  // R7: strap word only populates the three low capability bits
  a_r7_strap_fields: assert property (@(posedge clk) disable iff (!rstN)
    isStrap |-> (wordReg[WORD_BITS-1:3] == '0));

endmodule

// File: rtl/init_word_loader.sv
module init_word_loader
  import iwl_pkg::*;
#(
  parameter int HALF_CYCLES   = 50,
  parameter int WORD_BITS     = 16,
  parameter int EE_ADDR_BITS  = 6,
  parameter int EE_ADDR       = 0,
  parameter int SYNC_STAGES   = 2,
  parameter int PHY_ADDR_BITS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] modeSel,
  input  logic mcuClk,
  input  logic serData,
  input  logic strap10Hd,
  input  logic strap10Fd,
  input  logic strapT4,
  output logic eeClk,
  output logic eeCs,
  output logic eeDi,
  output logic [WORD_BITS-1:0] cfgWord,
  output logic cfgDone,
  output logic [PHY_ADDR_BITS-1:0] phyAddr
);
  dpCmd_t dpCmd;
  logic   wordDone;

  iwl_ctrl #(
    .HALF_CYCLES(HALF_CYCLES), .WORD_BITS(WORD_BITS),
    .EE_ADDR_BITS(EE_ADDR_BITS), .EE_ADDR(EE_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .mcuClk(mcuClk),
    .serData(serData), .wordDone(wordDone), .cmd(dpCmd),
    .eeClk(eeClk), .eeCs(eeCs), .eeDi(eeDi)
  );

  iwl_datapath #(
    .WORD_BITS(WORD_BITS), .PHY_ADDR_BITS(PHY_ADDR_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(dpCmd),
    .strap10Hd(strap10Hd), .strap10Fd(strap10Fd), .strapT4(strapT4),
    .wordDone(wordDone), .cfgWord(cfgWord), .phyAddr(phyAddr)
  );

  assign cfgDone = wordDone;

endmodule

// File: tb/sim_init_word_loader.sv
module sim_init_word_loader;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic mcuClk = 1'b0;
  logic serData = 1'b0;
  logic s10Hd = 1'b0, s10Fd = 1'b0, sT4 = 1'b0;
  logic eeClk, eeCs, eeDi, cfgDone;
  logic [15:0] cfgWord;
  logic [4:0]  phyAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // EEPROM model state
  logic [15:0] eeMem = '0;
  logic [8:0]  eeCmd = '0;
  int eeEdges = 0, eeBadEdges = 0, eeDiErrs = 0;
  int csCycles = 0, clkHighCycles = 0;

  init_word_loader #(.HALF_CYCLES(HALF)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .mcuClk(mcuClk),
    .serData(serData), .strap10Hd(s10Hd), .strap10Fd(s10Fd), .strapT4(sT4),
    .eeClk(eeClk), .eeCs(eeCs), .eeDi(eeDi),
    .cfgWord(cfgWord), .cfgDone(cfgDone), .phyAddr(phyAddr)
  );

  always #10 clk = ~clk;

  // serial memory: late-settling data after each rising clock
  always @(posedge eeClk) begin
    if (eeCs) begin
      int n;
      n = eeEdges;
      eeEdges = eeEdges + 1;
      if (n < 9) eeCmd = {eeCmd[7:0], eeDi};
      else if (eeDi) eeDiErrs = eeDiErrs + 1;
      if (n == 8) serData = 1'b0;
      else if (n >= 9 && n < 25) begin
        serData = ~eeMem[24-n];
        #50 serData = eeMem[24-n];
      end
    end else begin
      eeBadEdges = eeBadEdges + 1;
    end
  end

  always @(negedge clk) begin
    if (eeCs)  csCycles++;
    if (eeClk) clkHighCycles++;
  end

  function automatic logic [15:0] rev16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0; modeSel = m; mcuClk = 1'b0; serData = 1'b0;
    eeEdges = 0; eeBadEdges = 0; eeDiErrs = 0; eeCmd = '0;
    repeat (3) @(negedge clk);
    csCycles = 0; clkHighCycles = 0;
    rstN = 1'b1;
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    repeat (4) @(negedge clk);
    mcuClk = 1'b1;
    repeat (4) @(negedge clk);
    mcuClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; modeSel = 2'b01;
    repeat (2) @(negedge clk);
    chk("R2 done in reset", cfgDone, 0);
    chk("R2 word in reset", cfgWord, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 done idle", cfgDone, 0);
    chk("R10 word idle", cfgWord, 0);
    chk("R2 addr idle", phyAddr, 0);
    chk("R2 ee pins idle", {eeCs, eeClk, eeDi}, 0);
  endtask

  task automatic testStrap(input logic hd, input logic fd, input logic t4, input logic [1:0] m);
    s10Hd = hd; s10Fd = fd; sT4 = t4;
    doReset(m);
    @(negedge clk);
    chk("R7 strap done after first edge", cfgDone, 1);
    chk("R7 strap word", cfgWord, {13'b0, t4, fd, hd});
    chk("R7 strap addr zero", phyAddr, 0);
    modeSel = 2'b01;
    s10Hd = ~hd; s10Fd = ~fd; sT4 = ~t4;
    sendBit(1'b1);
    chk("R9 strap word frozen", cfgWord, {13'b0, t4, fd, hd});
    chk("R1 strap mode kept", cfgDone, 1);
  endtask

  task automatic testMcu(input logic [15:0] val);
    doReset(2'b01);
    @(negedge clk);
    modeSel = 2'b00; // R1: must not switch to strap
    for (int i = 0; i < 15; i++) sendBit(val[i]);
    repeat (8) @(negedge clk);
    chk("R10 not done after 15 bits", cfgDone, 0);
    chk("R10 word hidden", cfgWord, 0);
    chk("R1 mode change ignored", phyAddr, 0);
    sendBit(val[15]);
    repeat (8) @(negedge clk);
    chk("R3 done after 16 bits", cfgDone, 1);
    chk("R3 mcu word", cfgWord, val);
    chk("R8 mcu address", phyAddr, val[15:11]);
    chk("R1 no memory traffic", eeEdges, 0);
    for (int i = 0; i < 4; i++) sendBit(~val[i]);
    repeat (8) @(negedge clk);
    chk("R3 late edges ignored", cfgWord, val);
    chk("R9 done held", cfgDone, 1);
  endtask

  task automatic testEe(input logic [15:0] mem);
    eeMem = mem;
    doReset(2'b10);
    for (int i = 0; i < 2000 && !cfgDone; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R4 read command", eeCmd, 9'h180);
    chk("R4 clock count", eeEdges, 25);
    chk("R4 di quiet in data", eeDiErrs, 0);
    chk("R4 no clock without cs", eeBadEdges, 0);
    chk("R6 cs length", csCycles, 25 * 2 * HALF);
    chk("R6 high phase length", clkHighCycles, 25 * HALF);
    chk("R5 reversed word", cfgWord, rev16(mem));
    chk("R8 memory address", phyAddr, rev16(mem) >> 11);
    repeat (50) @(negedge clk);
    chk("R9 cs low after", {eeCs, eeClk}, 0);
    chk("R9 no further clocks", eeEdges, 25);
    chk("R9 done held ee", cfgDone, 1);
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testStrap(1'b1, 1'b0, 1'b1, 2'b00);
    testStrap(1'b0, 1'b1, 1'b0, 2'b11);
    testMcu(16'hA5C3);
    testMcu(16'h3E81);
    testEe(16'h1234);
    testEe(16'hF00D);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule